// File: doc/BRIEF.md
# Daisy-Chain DAC Frame Sender

This block is a host-side serial controller for a chain of DAC devices connected in series. All devices share one chip-select line and one serial clock. The data line runs from the sender into the first device, from each device's shift-register output into the next device, and so on to the end of the chain. For each device, the host supplies a 4-bit command, a 4-bit address and a 16-bit data value. The host can instead mark a device as idle for this transfer.

On a start strobe, the sender builds one 32-bit frame per device and joins the frames into a single stream. It drives chip-select low and shifts the whole stream out MSB first. The frame for the device farthest down the chain goes first. After the last bit it raises chip-select once, and every device then executes its own command at the same moment. The serial clock rate is set by a divider value. A minimum chip-select high time, also programmable, separates back-to-back transfers.

Top module: `chain_frame_sender`

## Requirements
- R1: After reset, cs_no is 1, sck_o is 0, sdo_o is 0, busy_o is 0 and done_o is 0.
- R2: The frame for device k is 32 bits, sent MSB first: 8 zero pad bits, then cmd_i[4k+3:4k], then addr_i[4k+3:4k], then data_i[16k+15:16k].
- R3: The device frames are sent in order from k = N_DEV-1 down to k = 0. Index 0 is the device nearest the sender, and its frame is sent last.
- R4: When idle_i[k] is 1, device k's frame carries command 4'b1111 (no operation), address 4'b0000 and data 16'h0000, whatever cmd_i, addr_i and data_i hold for it.
- R5: cs_no falls before the first rising edge of sck_o. It stays low for exactly N_DEV*32 rising edges and then rises once. sck_o is 0 whenever cs_no is 1.
- R6: sdo_o changes only while sck_o is low, that is, on falling edges. It holds steady for as long as sck_o is high.
- R7: Each half period of sck_o lasts div_i+1 clk_i cycles. div_i is captured when the transfer starts.
- R8: A start_i strobe that arrives while busy_o is 1 is ignored. It never causes another transfer.
- R9: Between transfers, cs_no stays high for at least gap_i+1 clk_i cycles, with gap_i captured at the start of the previous transfer. busy_o stays 1 during this hold-off. If start_i is held high, the next transfer begins exactly gap_i+1 cycles after cs_no rises.
- R10: done_o is a single-cycle pulse in the first cycle in which cs_no is high again after a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only while not busy |
| idle_i | input | N_DEV | Per-device idle flag, which selects the no-operation frame |
| cmd_i | input | 4*N_DEV | Per-device command codes |
| addr_i | input | 4*N_DEV | Per-device address codes |
| data_i | input | 16*N_DEV | Per-device data words |
| div_i | input | DIV_W | SCK half period in clk cycles, minus one |
| gap_i | input | GAP_W | Minimum chip-select high time in clk cycles, minus one |
| busy_o | output | 1 | Transfer or hold-off in progress |
| done_o | output | 1 | One-cycle pulse when chip-select rises |
| cs_no | output | 1 | Shared chip-select, active low |
| sck_o | output | 1 | Shared serial clock |
| sdo_o | output | 1 | Serial data into the first device |

## Verification
On every cycle, the assertions check these properties: the serial clock rests low while chip-select is high; data holds steady across each high phase of the clock; chip-select only falls out of a non-busy state; done never lasts longer than one cycle; and the bit counter and divider stay within range. Only the bench scenarios can show whether the stream has the right content and order. These cover the padding and field placement, the farthest-first frame order, the substitution of no-operation frames for idle devices, the exact count of rising edges per chip-select window, the measured clock period for each divider value, the exact hold-off time under a held start, and the loss of start strobes sent in mid-transfer.

// File: rtl/chain_pkg.sv
package chain_pkg;
  localparam int PAD_W   = 8;
  localparam int CMD_W   = 4;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 16;
  localparam int FRAME_W = PAD_W + CMD_W + ADDR_W + DATA_W;
  localparam logic [CMD_W-1:0] CMD_NOP = 4'b1111;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_END  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/chain_frame_builder.sv
module chain_frame_builder
  import chain_pkg::*;
#(
  parameter int N_DEV = 3,
  localparam int STREAM_W = N_DEV * FRAME_W
) (
  input  logic [N_DEV-1:0]        idle_i,
  input  logic [N_DEV*CMD_W-1:0]  cmd_i,
  input  logic [N_DEV*ADDR_W-1:0] addr_i,
  input  logic [N_DEV*DATA_W-1:0] data_i,
  output logic [STREAM_W-1:0]     stream_o
);
  // Device N_DEV-1 sits in the top slot, so it leaves first
  for (genvar g = 0; g < N_DEV; g++) begin : g_dev
    logic [FRAME_W-1:0] frame;
    always_comb begin
      if (idle_i[g])
        frame = {{PAD_W{1'b0}}, CMD_NOP, {ADDR_W{1'b0}}, {DATA_W{1'b0}}};
      else
        frame = {{PAD_W{1'b0}}, cmd_i[g*CMD_W +: CMD_W],
                 addr_i[g*ADDR_W +: ADDR_W], data_i[g*DATA_W +: DATA_W]};
    end
    assign stream_o[g*FRAME_W +: FRAME_W] = frame;
  end
endmodule

// File: rtl/chain_sck_divider.sv
module chain_sck_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q <= div_i))
    else $error("divider count past limit");
endmodule

// File: rtl/chain_frame_sender.sv
module chain_frame_sender
  import chain_pkg::*;
#(
  parameter int N_DEV = 3,
  parameter int DIV_W = 8,
  parameter int GAP_W = 8,
  localparam int STREAM_W = N_DEV * FRAME_W,
  localparam int CNT_W    = $clog2(STREAM_W + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [N_DEV-1:0]        idle_i,
  input  logic [N_DEV*CMD_W-1:0]  cmd_i,
  input  logic [N_DEV*ADDR_W-1:0] addr_i,
  input  logic [N_DEV*DATA_W-1:0] data_i,
  input  logic [DIV_W-1:0]        div_i,
  input  logic [GAP_W-1:0]        gap_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    cs_no,
  output logic                    sck_o,
  output logic                    sdo_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(STREAM_W - 1);

  tx_state_e             state_q;
  logic [STREAM_W-1:0]   stream, shreg_q;
  logic [CNT_W-1:0]      bit_cnt_q;
  logic [DIV_W-1:0]      div_q;
  logic [GAP_W-1:0]      gap_q, gap_cnt_q;
  logic                  tick;

  chain_frame_builder #(.N_DEV(N_DEV)) u_build (
    .idle_i  (idle_i),
    .cmd_i   (cmd_i),
    .addr_i  (addr_i),
    .data_i  (data_i),
    .stream_o(stream)
  );

  chain_sck_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (state_q != ST_IDLE),
    .div_i (div_q),
    .tick_o(tick)
  );

  assign busy_o = (state_q != ST_IDLE) || (gap_cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      shreg_q   <= '0;
      bit_cnt_q <= '0;
      div_q     <= '0;
      gap_q     <= '0;
      gap_cnt_q <= '0;
      cs_no     <= 1'b1;
      sck_o     <= 1'b0;
      sdo_o     <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (gap_cnt_q != '0) gap_cnt_q <= gap_cnt_q - 1'b1;
          if (start_i && gap_cnt_q == '0) begin
            shreg_q   <= stream;
            sdo_o     <= stream[STREAM_W-1];
            cs_no     <= 1'b0;
            bit_cnt_q <= '0;
            div_q     <= div_i;
            gap_q     <= gap_i;
            state_q   <= ST_LOW;
          end
        end
        ST_LOW: if (tick) begin
          sck_o   <= 1'b1;   // devices sample here
          state_q <= ST_HIGH;
        end
        ST_HIGH: if (tick) begin
          sck_o <= 1'b0;
          if (bit_cnt_q == LAST_BIT) begin
            sdo_o   <= 1'b0;
            state_q <= ST_END;
          end else begin
            shreg_q   <= shreg_q << 1;
            sdo_o     <= shreg_q[STREAM_W-2];
            bit_cnt_q <= bit_cnt_q + 1'b1;
            state_q   <= ST_LOW;
          end
        end
        ST_END: if (tick) begin
          cs_no     <= 1'b1;
          done_o    <= 1'b1;
          gap_cnt_q <= gap_q;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_sck_rest_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o)
    else $error("sck high with chip-select released");

  p_bit_cnt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |-> (bit_cnt_q <= LAST_BIT))
    else $error("bit counter overrun");

  p_sdo_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> $stable(sdo_o))
    else $error("sdo moved while sck high");

  p_start_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> $past(!busy_o))
    else $error("transfer began while busy");

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o)
    else $error("done longer than one cycle");

  p_done_cs_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && $past(!cs_no)))
    else $error("done not aligned with chip-select rise");
endmodule

// File: tb/chain_frame_sender_tb_top.sv
module chain_frame_sender_tb_top;
  localparam int N   = 3;
  localparam int SW  = N * 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [N-1:0]    idle = '0;
  logic [N*4-1:0]  cmd = '0, addr = '0;
  logic [N*16-1:0] data = '0;
  logic [7:0]      div = '0, gap = '0;
  logic busy, done, cs_n, sck, sdo;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  chain_frame_sender #(.N_DEV(N), .DIV_W(8), .GAP_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .idle_i(idle),
    .cmd_i(cmd), .addr_i(addr), .data_i(data), .div_i(div), .gap_i(gap),
    .busy_o(busy), .done_o(done), .cs_no(cs_n), .sck_o(sck), .sdo_o(sdo)
  );

  // monitor, sampled on falling clk edges
  logic [SW-1:0] rx;
  int rx_cnt = 0, last_cnt = 0, frames = 0, falls = 0;
  int per_cnt = 0, per_min = 0, per_max = 0, hi_cnt = 0, last_hi = 0;
  int done_cycles = 0, done_bad = 0, sck_bad = 0;
  logic prev_sck = 1'b0, prev_cs = 1'b1, prev_sdo = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      per_cnt++;
      if (cs_n && sck) sck_bad++;
      if (sck && prev_sck && sdo !== prev_sdo) sck_bad++;
      if (done) begin
        done_cycles++;
        if (!(cs_n && !prev_cs)) done_bad++;
      end
      if (prev_cs && !cs_n) begin
        falls++; rx_cnt = 0; per_min = 1000000; per_max = 0; per_cnt = 0;
        last_hi = hi_cnt;
      end
      if (cs_n) hi_cnt++; else if (prev_cs) hi_cnt = 0;
      if (!cs_n && sck && !prev_sck) begin
        if (rx_cnt > 0) begin
          if (per_cnt < per_min) per_min = per_cnt;
          if (per_cnt > per_max) per_max = per_cnt;
        end
        per_cnt = 0;
        rx = {rx[SW-2:0], sdo};
        rx_cnt++;
      end
      if (!prev_cs && cs_n) begin
        frames++; last_cnt = rx_cnt; hi_cnt = 1;
      end
      prev_sck = sck; prev_cs = cs_n; prev_sdo = sdo;
    end
  end

  function automatic logic [SW-1:0] exp_stream(logic [N-1:0] id, logic [N*4-1:0] c,
      logic [N*4-1:0] a, logic [N*16-1:0] d);
    logic [SW-1:0] s = '0;
    for (int k = N - 1; k >= 0; k--) begin
      logic [31:0] f;
      if (id[k]) f = {8'h00, 4'hF, 4'h0, 16'h0000};
      else       f = {8'h00, c[k*4 +: 4], a[k*4 +: 4], d[k*16 +: 16]};
      s = {s[SW-33:0], f};
    end
    return s;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic check_stream(string req, logic [SW-1:0] e);
    n_chk++;
    if (rx !== e) begin
      n_bad++;
      $display("FAIL %s stream: actual %h expected %h", req, rx, e);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_one(string req);
    int f0 = frames;
    logic [SW-1:0] e = exp_stream(idle, cmd, addr, data);
    pulse_start();
    wait_idle();
    check(frames == f0 + 1, req, "cs rises per transfer", frames - f0, 1);
    check(last_cnt == SW, "R5", "rising edges in window", last_cnt, SW);
    check_stream(req, e);
    check(per_min == 2 * (div + 1) && per_max == 2 * (div + 1), "R7",
          "sck period", per_max, 2 * (div + 1));
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cs_n == 1 && sck == 0 && sdo == 0 && busy == 0 && done == 0, "R1",
          "reset outputs", {cs_n, sck, sdo, busy, done}, 5'b10000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 directed field placement, single active device pattern
    cmd = 12'h321; addr = 12'h0F2; data = 48'hA5A5_1234_8001;
    run_one("R2");
    // R3 order: distinct per-device patterns
    cmd = 12'h123; addr = 12'h456; data = 48'hFFFF_0000_C3C3; div = 8'd2;
    run_one("R3");
    // R4 idle substitution with nonzero inputs
    idle = 3'b101; cmd = 12'h333; addr = 12'hFFF; data = '1; div = 8'd0;
    run_one("R4");
    idle = 3'b111;
    run_one("R4");
    idle = '0;

    // random transfers
    for (int i = 0; i < 12; i++) begin
      idle = N'($urandom); cmd = 12'($urandom); addr = 12'($urandom);
      data = {$urandom, $urandom} & {48{1'b1}};
      div = 8'($urandom_range(0, 3)); gap = 8'($urandom_range(0, 6));
      run_one("R2");
    end

    // R6 sdo stable while sck high, R5 sck low with cs high
    check(sck_bad == 0, "R6", "sdo/sck edge violations", sck_bad, 0);
    // R10 done pulses
    check(done_cycles == frames && done_bad == 0, "R10", "done pulses",
          done_cycles, frames);

    // R8 starts during a transfer are dropped
    begin
      int f0;
      div = 8'd1; gap = 8'd2; idle = '0;
      f0 = falls;
      pulse_start();
      repeat (20) begin
        pulse_start();
        repeat (3) @(negedge clk);
      end
      wait_idle();
      repeat (30) @(negedge clk);
      check(falls == f0 + 1, "R8", "transfers after busy starts", falls - f0, 1);
      check(cs_n == 1, "R8", "cs idle after ignored starts", cs_n, 1);
    end

    // R9 hold-off with start held high
    for (int g = 0; g < 3; g++) begin
      int f0;
      gap = 8'(g * 4 + 1); div = 8'd0;
      @(negedge clk); start = 1'b1;
      f0 = falls;
      while (falls < f0 + 2) @(negedge clk);
      start = 1'b0;
      check(last_hi == gap + 1, "R9", "cs high cycles", last_hi, gap + 1);
      wait_idle();
      repeat (gap + 2) @(negedge clk);
    end

    check(sck_bad == 0, "R5", "sck high while cs high", sck_bad, 0);
    check(done_bad == 0, "R10", "done alignment", done_bad, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule